// File: doc/BRIEF.md
# Single-Bank DRAM Command Sequencer

This block owns the row state of one DRAM bank. Each read or write request it accepts, given as a row and a column, becomes a short ordered run of bank commands: a precharge to close a different open row, an activate to open the wanted row, and a column read or write. Programmable minimum gaps separate the commands. Each request finishes with a one-cycle response pulse that carries a classification of the access.

A policy input picks the page mode for each request. In open-page mode the row stays open after the access, so a later request to the same row needs only a column command. In closed-page mode the block precharges the bank straight after the access. It accepts one request at a time and sends out at most one command per cycle. Two saturating counters tally row hits and row conflicts for statistics.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset the bank is closed, `req_ready_o` is 1, no command or response is driven, and both statistics counters read 0.
- R2: A request whose row equals the open row issues only a column command, in the cycle after acceptance, and responds with class 0 (hit).
- R3: A request to a closed bank issues ACTIVATE (code 1) with the request row, then the column command, with no PRECHARGE, and responds with class 1 (empty).
- R4: A request to a row other than the open one issues PRECHARGE (code 0) with the old row in the cycle after acceptance, then ACTIVATE, then the column command, and responds with class 2 (conflict).
- R5: ACTIVATE comes no earlier than `t_rp_i` cycles after the last PRECHARGE. The column command comes exactly `t_rcd_i` cycles after ACTIVATE. The response pulse comes exactly `t_cl_i` cycles after the column command. Every gap is at least 1, and no command is issued in any other cycle.
- R6: In open-page mode (`close_page_i`=0) the row stays open after the response, so the next request to that row is a hit.
- R7: In closed-page mode (`close_page_i`=1) PRECHARGE is issued in the cycle after the response, and the bank is then closed.
- R8: `req_ready_o` is 0 from the cycle after acceptance until the sequence ends. A request held valid during that time is not taken.
- R9: The column command is READ (code 2) for `req_write_i`=0 and WRITE (code 3) for `req_write_i`=1. It carries the accepted column on `cmd_col_o`. ACTIVATE and PRECHARGE carry their row on `cmd_row_o`.
- R10: The hit counter and the conflict counter each add one in the cycle after a response of their class, and each holds at its all-ones value.
- R11: The page policy is sampled when a request is accepted. Changing `close_page_i` later has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| close_page_i | input | 1 | 1 = closed-page, 0 = open-page |
| t_rp_i | input | TW | Precharge-to-activate gap in cycles |
| t_rcd_i | input | TW | Activate-to-column gap in cycles |
| t_cl_i | input | TW | Column-to-response latency in cycles |
| cmd_valid_o | output | 1 | Command valid this cycle |
| cmd_o | output | 2 | 0 PRE, 1 ACT, 2 READ, 3 WRITE |
| cmd_row_o | output | ROW_W | Row for ACT/PRE |
| cmd_col_o | output | COL_W | Column for READ/WRITE |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_class_o | output | 2 | 0 hit, 1 empty, 2 conflict |
| hit_count_o | output | CNT_W | Saturating hit count |
| conflict_count_o | output | CNT_W | Saturating conflict count |

## Verification
On every cycle the assertions check several timing and state rules. The precharge-to-activate, activate-to-column and column-to-response gaps are measured against the programmed values. An activate is allowed only on a closed bank and a precharge only on an open one. Ready must drop after acceptance, a closed-page response must be followed by a precharge, and the counters must step and saturate correctly. Other behaviours can be shown only by the bench's scenarios against its reference model. These are the classification of each request, the row and column each command carries, the policy being latched at acceptance, activate waiting out a precharge left over from the previous request, and behaviour under minimum gaps.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } bank_cmd_e;

  typedef enum logic [1:0] {
    RES_HIT      = 2'd0,
    RES_EMPTY    = 2'd1,
    RES_CONFLICT = 2'd2
  } access_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_DATA,
    ST_CLOSE
  } seq_state_e;
endpackage

// File: rtl/bank_gap_timer.sv
module bank_gap_timer #(
  parameter int TW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] gap_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  // gap of N cycles: next issue N cycles after this load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= (gap_i == '0) ? '0 : gap_i - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_load_when_expired_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> zero_o);
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import bank_seq_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic [ROW_W-1:0] probe_row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] open_row_o,
  output access_res_e      res_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= act_row_i;
    end else if (pre_i) begin
      open_q <= 1'b0;
    end
  end

  always_comb begin
    if (!open_q)                   res_o = RES_EMPTY;
    else if (probe_row_i == row_q) res_o = RES_HIT;
    else                           res_o = RES_CONFLICT;
  end

  assign open_o     = open_q;
  assign open_row_o = row_q;

  p_act_on_closed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q);
  p_pre_on_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> open_q);
  p_act_opens_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (open_q && row_q == $past(act_row_i)));
endmodule

// File: rtl/bank_sat_ctr.sv
module bank_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MaxVal = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (inc_i && cnt_q != MaxVal)  cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  p_sat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MaxVal) |=> (cnt_q == MaxVal));
  p_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != MaxVal) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bank_seq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TW    = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             close_page_i,
  input  logic [TW-1:0]    t_rp_i,
  input  logic [TW-1:0]    t_rcd_i,
  input  logic [TW-1:0]    t_cl_i,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_class_o,
  output logic [CNT_W-1:0] hit_count_o,
  output logic [CNT_W-1:0] conflict_count_o
);
  localparam int GW = TW + 1;

  seq_state_e       state_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic             pol_q;
  access_res_e      res_q;

  logic             issue;
  bank_cmd_e        cmd;
  logic             rsp_valid;
  logic             tmr_load;
  logic [TW-1:0]    tmr_gap;
  logic             tmr_zero;
  logic             bank_open;
  logic [ROW_W-1:0] open_row;
  access_res_e      probe_res;
  logic             accept;

  bank_gap_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .gap_i  (tmr_gap),
    .zero_o (tmr_zero)
  );

  bank_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (issue && cmd == CMD_ACT),
    .pre_i       (issue && cmd == CMD_PRE),
    .act_row_i   (row_q),
    .probe_row_i (req_row_i),
    .open_o      (bank_open),
    .open_row_o  (open_row),
    .res_o       (probe_res)
  );

  bank_sat_ctr #(.W(CNT_W)) u_hits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (rsp_valid && res_q == RES_HIT),
    .count_o (hit_count_o)
  );

  bank_sat_ctr #(.W(CNT_W)) u_conflicts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (rsp_valid && res_q == RES_CONFLICT),
    .count_o (conflict_count_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    issue     = 1'b0;
    cmd       = CMD_PRE;
    rsp_valid = 1'b0;
    tmr_load  = 1'b0;
    tmr_gap   = '0;
    unique case (state_q)
      ST_PRE, ST_CLOSE: if (tmr_zero) begin
        issue = 1'b1; cmd = CMD_PRE; tmr_load = 1'b1; tmr_gap = t_rp_i;
      end
      ST_ACT: if (tmr_zero) begin
        issue = 1'b1; cmd = CMD_ACT; tmr_load = 1'b1; tmr_gap = t_rcd_i;
      end
      ST_COL: if (tmr_zero) begin
        issue = 1'b1; cmd = wr_q ? CMD_WR : CMD_RD; tmr_load = 1'b1; tmr_gap = t_cl_i;
      end
      ST_DATA: rsp_valid = tmr_zero;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      pol_q   <= 1'b0;
      res_q   <= RES_HIT;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          row_q <= req_row_i;
          col_q <= req_col_i;
          wr_q  <= req_write_i;
          pol_q <= close_page_i;
          res_q <= probe_res;
          unique case (probe_res)
            RES_HIT:   state_q <= ST_COL;
            RES_EMPTY: state_q <= ST_ACT;
            default:   state_q <= ST_PRE;
          endcase
        end
        ST_PRE:   if (issue) state_q <= ST_ACT;
        ST_ACT:   if (issue) state_q <= ST_COL;
        ST_COL:   if (issue) state_q <= ST_DATA;
        ST_DATA:  if (rsp_valid) state_q <= pol_q ? ST_CLOSE : ST_IDLE;
        ST_CLOSE: if (issue) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = issue;
  assign cmd_o       = cmd;
  assign cmd_row_o   = (state_q == ST_ACT) ? row_q : open_row;
  assign cmd_col_o   = col_q;
  assign rsp_valid_o = rsp_valid;
  assign rsp_class_o = res_q;

  // checker state: last command and cycles since it
  bank_cmd_e      chk_last_q;
  logic           chk_seen_q;
  logic [GW-1:0]  chk_gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_last_q <= CMD_PRE;
      chk_seen_q <= 1'b0;
      chk_gap_q  <= '0;
    end else if (cmd_valid_o) begin
      chk_last_q <= bank_cmd_e'(cmd_o);
      chk_seen_q <= 1'b1;
      chk_gap_q  <= GW'(1);
    end else if (chk_gap_q != '1) begin
      chk_gap_q  <= chk_gap_q + 1'b1;
    end
  end

  p_act_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_ACT && chk_seen_q && chk_last_q == CMD_PRE)
      |-> (chk_gap_q >= {1'b0, t_rp_i}));
  p_col_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o[1] && chk_seen_q && chk_last_q == CMD_ACT)
      |-> (chk_gap_q == {1'b0, t_rcd_i}));
  p_rsp_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (chk_seen_q && chk_last_q[1] && chk_gap_q == {1'b0, t_cl_i}));
  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  p_close_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && pol_q) |=> (cmd_valid_o && cmd_o == CMD_PRE));
  p_act_needs_closed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_ACT) |-> !bank_open);
endmodule

// File: tb/bank_cmd_seq_tb.sv
module bank_cmd_seq_tb;
  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int TW    = 5;
  localparam int CNT_W = 4;
  localparam int CMAX  = 15;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             close_page = 1'b0;
  logic [TW-1:0]    t_rp = 5'd3, t_rcd = 5'd2, t_cl = 5'd4;
  logic             cmd_valid;
  logic [1:0]       cmd;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic             rsp_valid;
  logic [1:0]       rsp_class;
  logic [CNT_W-1:0] hit_cnt, conf_cnt;

  always #4 clk = ~clk;

  bank_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_row_i(req_row), .req_col_i(req_col), .close_page_i(close_page),
    .t_rp_i(t_rp), .t_rcd_i(t_rcd), .t_cl_i(t_cl),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .rsp_valid_o(rsp_valid), .rsp_class_o(rsp_class),
    .hit_count_o(hit_cnt), .conflict_count_o(conf_cnt)
  );

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit run = 1'b0, done = 1'b0;

  // reference model state
  bit m_open = 1'b0;
  int m_row = 0;
  int last_pre = -1000;
  int idle_at = 0;
  int m_hits = 0, m_confs = 0, e_hits = 0, e_confs = 0;
  int exp_cmd[int];
  int exp_fld[int];
  string exp_tag[int];
  int exp_rsp[int];
  int hit_at[int];
  int conf_at[int];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (run) begin
    if (hit_at.exists(cyc))  e_hits  = hit_at[cyc];
    if (conf_at.exists(cyc)) e_confs = conf_at[cyc];
    if (exp_cmd.exists(cyc)) begin
      chk(cmd_valid && int'(cmd) == exp_cmd[cyc], exp_tag[cyc], "cmd code", cmd_valid ? int'(cmd) : -1, exp_cmd[cyc]);
      if (exp_cmd[cyc] < 2) chk(int'(cmd_row) == exp_fld[cyc], "R9", "cmd row", int'(cmd_row), exp_fld[cyc]);
      else                  chk(int'(cmd_col) == exp_fld[cyc], "R9", "cmd col", int'(cmd_col), exp_fld[cyc]);
    end else begin
      chk(!cmd_valid, "R5", "unexpected cmd", int'(cmd), -1);
    end
    if (exp_rsp.exists(cyc))
      chk(rsp_valid && int'(rsp_class) == exp_rsp[cyc],
          exp_rsp[cyc] == 0 ? "R2" : (exp_rsp[cyc] == 1 ? "R3" : "R4"), "rsp class",
          rsp_valid ? int'(rsp_class) : -1, exp_rsp[cyc]);
    else
      chk(!rsp_valid, "R5", "unexpected rsp", int'(rsp_class), -1);
    chk(req_ready == (cyc >= idle_at), "R8", "ready", int'(req_ready), int'(cyc >= idle_at));
    chk(int'(hit_cnt) == e_hits, "R10", "hit count", int'(hit_cnt), e_hits);
    chk(int'(conf_cnt) == e_confs, "R10", "conflict count", int'(conf_cnt), e_confs);
  end

  // a = acceptance cycle (first cycle in which the sequence runs)
  task automatic schedule(input int a, input bit w, input int row, input int col, input bit pol, input bit flip);
    int act, colc, rsp, cls;
    string ptag;
    if (m_open && row == m_row) begin
      cls = 0; colc = a;
    end else if (!m_open) begin
      cls = 1;
      act = (a > last_pre + int'(t_rp)) ? a : last_pre + int'(t_rp);
      exp_cmd[act] = 1; exp_fld[act] = row; exp_tag[act] = "R3";
      colc = act + int'(t_rcd);
    end else begin
      cls = 2;
      exp_cmd[a] = 0; exp_fld[a] = m_row; exp_tag[a] = "R4";
      last_pre = a;
      act = a + int'(t_rp);
      exp_cmd[act] = 1; exp_fld[act] = row; exp_tag[act] = "R4";
      colc = act + int'(t_rcd);
    end
    exp_cmd[colc] = w ? 3 : 2; exp_fld[colc] = col;
    exp_tag[colc] = (cls == 0) ? "R2" : "R9";
    rsp = colc + int'(t_cl);
    exp_rsp[rsp] = cls;
    if (cls == 0 && m_hits < CMAX)  begin m_hits++;  hit_at[rsp+1]  = m_hits;  end
    if (cls == 2 && m_confs < CMAX) begin m_confs++; conf_at[rsp+1] = m_confs; end
    ptag = flip ? "R11" : "R7";
    if (pol) begin
      exp_cmd[rsp+1] = 0; exp_fld[rsp+1] = row; exp_tag[rsp+1] = ptag;
      last_pre = rsp + 1; m_open = 1'b0; m_row = row; idle_at = rsp + 2;
    end else begin
      m_open = 1'b1; m_row = row; idle_at = rsp + 1;
    end
  endtask

  // request stays valid afterwards so the busy window sees a pending request (R8)
  task automatic req(input bit w, input int row, input int col, input bit pol, input bit flip);
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_row = ROW_W'(row); req_col = COL_W'(col); close_page = pol;
    while (!req_ready) @(negedge clk);
    k = cyc;
    @(posedge clk);
    schedule(k + 1, w, row, col, pol, flip);
    @(negedge clk);
    if (flip) close_page = ~pol;
    req_row = ROW_W'(row + 77);
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc < idle_at + int'(t_rp) + 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready && !cmd_valid && !rsp_valid, "R1", "idle outputs", {req_ready, cmd_valid, rsp_valid}, 3'b100);
    chk(hit_cnt == 0 && conf_cnt == 0, "R1", "counters", int'(hit_cnt) + int'(conf_cnt), 0);
    idle_at = cyc;
    run = 1'b1;

    // open-page: empty (R3), hits (R2, R6), write (R9), conflict (R4)
    req(1'b0, 5, 1, 1'b0, 1'b0);
    req(1'b0, 5, 2, 1'b0, 1'b0);
    req(1'b1, 5, 3, 1'b0, 1'b0);
    req(1'b0, 9, 4, 1'b0, 1'b0);
    // closed-page hit then close (R7); next empty waits out the close precharge (R5)
    req(1'b1, 9, 5, 1'b1, 1'b0);
    req(1'b0, 2, 6, 1'b1, 1'b0);
    // policy latched at acceptance (R11)
    req(1'b0, 2, 7, 1'b0, 1'b1);
    req(1'b0, 2, 8, 1'b0, 1'b0);
    req(1'b1, 2, 9, 1'b1, 1'b1);
    drain();

    // minimum gaps
    t_rp = 5'd1; t_rcd = 5'd1; t_cl = 5'd1;
    req(1'b0, 3, 10, 1'b0, 1'b0);
    req(1'b1, 4, 11, 1'b0, 1'b0);
    req(1'b0, 4, 12, 1'b1, 1'b0);
    req(1'b1, 6, 13, 1'b1, 1'b0);
    drain();

    // longer gaps, saturate both counters (R10)
    t_rp = 5'd2; t_rcd = 5'd3; t_cl = 5'd2;
    for (int i = 0; i < 20; i++) req(i[0], 8, i, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) req(1'b0, 20 + i, i, 1'b0, 1'b0);
    drain();
    repeat (5) @(negedge clk);
    chk(hit_cnt == 4'hF && conf_cnt == 4'hF, "R10", "saturated", {hit_cnt, conf_cnt}, 8'hFF);
    run = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule